// File: doc/BRIEF.md
# Binary64 to Integer Converter with Selectable Overflow Policy

This block takes a 64-bit IEEE-754 double-precision operand and turns it into a 64-bit integer register value. The target can be a signed or unsigned integer of 32 or 64 bits. The operand is first rounded to an integral value, using either the dynamic rounding mode or forced truncation. A policy code then decides what happens when that value does not fit the target: it is clamped to the target limits, or it wraps modulo the target width. Two clamping policies are available, and they differ only in how a NaN is treated.

Next to the integer, the block reports the status a floating-point status register and an integer overflow summary need: inexact, magnitude-increased-by-rounding, invalid conversion, signalling NaN, an overflow indication that can be enabled per operation, and an illegal-policy indication. If invalid-operation trapping is enabled and the conversion is invalid, the write-enable is dropped, so the destination register keeps its old value. The block accepts one operation per cycle and returns each result one cycle later.

Top module: `f2i_convert`

## Requirements
- R1: A result appears on the outputs with `out_valid` high exactly one clock after `in_valid` is sampled high, and `out_valid` is low in any cycle that follows an idle input cycle. Reset clears `out_valid` and drives every output to zero.
- R2: Rounding to an integral value truncates when `in_mode[0]` is 1. Otherwise `in_rmode` selects the mode: 00 = nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward −infinity.
- R3: With `in_mode[2:1]` = 00 (clamp policy), a NaN gives the target minimum, a rounded value above the target maximum gives the maximum, and a value below the minimum gives the minimum. Target codes on `in_type` are 0 = signed 32, 1 = unsigned 32, 2 = signed 64, 3 = unsigned 64. The signed minimums are −2^31 and −2^63, and the unsigned minimum is 0.
- R4: With `in_mode[2:1]` = 01, the behaviour matches R3 except that a NaN gives zero.
- R5: With `in_mode[2:1]` = 10 (wrap policy), infinity, NaN and any rounded magnitude of at least 2^128 give zero. Any other value gives the low 64 bits of its two's-complement form.
- R6: A signed 32-bit result is sign-extended from bit 31 to 64 bits, and an unsigned 32-bit result is zero-extended.
- R7: `out_cvt_invalid` is set when the operand is NaN or the rounded value differs from the integer produced. In that case `out_inexact` and `out_frac_rnd` are 0. Otherwise `out_inexact` reports that rounding discarded nonzero fraction bits, and `out_frac_rnd` reports that rounding increased the magnitude.
- R8: `out_overflow` equals `out_cvt_invalid` when `in_ovf_en` was 1 for that operation, and is 0 when it was 0.
- R9: When `in_inv_en` is 1 and the conversion is invalid, `out_wr_en` is 0. Whenever `out_wr_en` is 0, `out_result` reads zero.
- R10: `out_snan` is set for a NaN whose fraction bit 51 (the quiet bit) is clear, and it is always accompanied by `out_cvt_invalid`.
- R11: Policy code `in_mode[2:1]` = 11 raises `out_illegal`, drops `out_wr_en`, and reports no other status flag.
- R12: `out_frac_rnd` is never set without `out_inexact`. Both zeros convert exactly to 0, and subnormal operands round like any other fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_operand | input | 64 | Binary64 operand bits |
| in_type | input | 2 | Target integer type code |
| in_mode | input | 3 | Bit 0 forces truncation; bits 2:1 select the overflow policy |
| in_rmode | input | 2 | Dynamic rounding mode |
| in_inv_en | input | 1 | Invalid-operation trap enable |
| in_ovf_en | input | 1 | Overflow reporting enable |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Shaped integer result (zero when not written) |
| out_wr_en | output | 1 | Destination write enable |
| out_overflow | output | 1 | Integer overflow indication |
| out_inexact | output | 1 | Inexact result |
| out_frac_rnd | output | 1 | Magnitude increased by rounding |
| out_cvt_invalid | output | 1 | Invalid conversion |
| out_snan | output | 1 | Signalling NaN operand |
| out_illegal | output | 1 | Illegal policy code |

## Verification
The assertions assume that every control input (`in_type`, `in_mode`, `in_rmode`, `in_inv_en`, `in_ovf_en`) carries a known value whenever `in_valid` is high, and that an enable whose effect is checked one cycle later is the one sampled together with the operation. The stimulus meets this by driving every input on the falling edge, one complete operation per cycle. All controls are set in the same step, and everything returns to zero while the input is idle.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

  localparam int F64_W  = 64;
  localparam int EXP_W  = 11;
  localparam int MAN_W  = 52;
  localparam int SIG_W  = MAN_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int INT_W  = 64;
  localparam int HALF_W = INT_W / 2;
  localparam int MAG_W  = 2 * INT_W + 1;
  localparam int GRS_W  = SIG_W + 2;
  localparam int EXT_W  = SIG_W + GRS_W;
  localparam int MAX_RSH = SIG_W + 1;
  localparam int SH_W   = 7;

  typedef enum logic [1:0] {
    K_S32 = 2'd0,
    K_U32 = 2'd1,
    K_S64 = 2'd2,
    K_U64 = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    POL_CLAMP_MIN  = 2'd0,
    POL_CLAMP_ZERO = 2'd1,
    POL_WRAP       = 2'd2,
    POL_BAD        = 2'd3
  } policy_e;

  typedef struct packed {
    logic             neg;
    logic             nan;
    logic             snan;
    logic             inf;
    logic             huge;
    logic             lost;
    logic             bumped;
    logic [MAG_W-1:0] mag;
  } rounded_t;

  // Magnitude increment decision for one rounding mode.
  function automatic logic round_step(input logic [1:0] rm, input logic neg,
                                      input logic lsb, input logic guard,
                                      input logic sticky);
    case (rm)
      2'b00:   return guard & (sticky | lsb);
      2'b01:   return 1'b0;
      2'b10:   return ~neg & (guard | sticky);
      default: return neg & (guard | sticky);
    endcase
  endfunction

  // Does sign/magnitude fit the target type exactly?
  function automatic logic kind_fits(input kind_e k, input logic neg,
                                     input logic [MAG_W-1:0] mag);
    logic [MAG_W-1:0] lim;
    case (k)
      K_S32: lim = neg ? (MAG_W'(1) << (HALF_W - 1))
                       : (MAG_W'(1) << (HALF_W - 1)) - MAG_W'(1);
      K_U32: lim = neg ? '0 : (MAG_W'(1) << HALF_W) - MAG_W'(1);
      K_S64: lim = neg ? (MAG_W'(1) << (INT_W - 1))
                       : (MAG_W'(1) << (INT_W - 1)) - MAG_W'(1);
      default: lim = neg ? '0 : (MAG_W'(1) << INT_W) - MAG_W'(1);
    endcase
    return mag <= lim;
  endfunction

  function automatic logic [INT_W-1:0] kind_min(input kind_e k);
    case (k)
      K_S32:   return INT_W'(1) << (HALF_W - 1);
      K_S64:   return INT_W'(1) << (INT_W - 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic [INT_W-1:0] kind_max(input kind_e k);
    case (k)
      K_S32:   return (INT_W'(1) << (HALF_W - 1)) - INT_W'(1);
      K_U32:   return (INT_W'(1) << HALF_W) - INT_W'(1);
      K_S64:   return ~(INT_W'(1) << (INT_W - 1));
      default: return '1;
    endcase
  endfunction

  // Width shaping of the final register value.
  function automatic logic [INT_W-1:0] kind_shape(input kind_e k,
                                                  input logic [INT_W-1:0] v);
    case (k)
      K_S32:   return {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
      K_U32:   return {{HALF_W{1'b0}}, v[HALF_W-1:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/f2i_unpack_round.sv
`timescale 1ns/1ps
module f2i_unpack_round
  import f2i_pkg::*;
(
  input  logic [F64_W-1:0] op_bits,
  input  logic [1:0]       rmode,
  input  logic             force_trunc,
  output rounded_t         rv
);

  localparam int UNB_W = EXP_W + 2;
  localparam logic signed [UNB_W-1:0] UNB_MAN   = UNB_W'(MAN_W);
  localparam logic signed [UNB_W-1:0] UNB_LIM   = UNB_W'(2 * INT_W);
  localparam logic signed [UNB_W-1:0] UNB_FLOOR = UNB_W'(MAN_W - MAX_RSH);
  localparam logic signed [UNB_W-1:0] UNB_SUB   = UNB_W'(1 - BIAS);
  localparam logic signed [UNB_W-1:0] UNB_BIAS  = UNB_W'(BIAS);

  logic                    sign;
  logic [EXP_W-1:0]        efld;
  logic [MAN_W-1:0]        ffld;
  logic                    special;
  logic                    huge;
  logic [SIG_W-1:0]        sig;
  logic signed [UNB_W-1:0] unb;
  logic                    go_left;
  logic [SH_W-1:0]         lsh;
  logic [SH_W-1:0]         rsh;
  logic [EXT_W-1:0]        ext;
  logic [MAG_W-1:0]        trunc_mag;
  logic                    guard;
  logic                    sticky;
  logic                    inc;
  logic [1:0]              rm_eff;

  assign sign    = op_bits[F64_W-1];
  assign efld    = op_bits[F64_W-2 -: EXP_W];
  assign ffld    = op_bits[MAN_W-1:0];
  assign special = &efld;
  assign sig     = {|efld, ffld};
  assign unb     = (efld == '0) ? UNB_SUB
                                : $signed({2'b00, efld}) - UNB_BIAS;
  assign huge    = ~special & (unb >= UNB_LIM);
  assign go_left = unb >= UNB_MAN;
  assign lsh     = SH_W'(unb - UNB_MAN);
  assign rsh     = (unb < UNB_FLOOR) ? SH_W'(MAX_RSH) : SH_W'(UNB_MAN - unb);
  assign ext     = {sig, {GRS_W{1'b0}}} >> rsh;
  assign rm_eff  = force_trunc ? 2'b01 : rmode;

  always_comb begin
    trunc_mag = '0;
    guard     = 1'b0;
    sticky    = 1'b0;
    if (!special && !huge) begin
      if (go_left) begin
        trunc_mag = MAG_W'(sig) << lsh;
      end else begin
        trunc_mag = MAG_W'(ext[EXT_W-1 -: SIG_W]);
        guard     = ext[GRS_W-1];
        sticky    = |ext[GRS_W-2:0];
      end
    end
    inc = round_step(rm_eff, sign, trunc_mag[0], guard, sticky);
  end

  always_comb begin
    rv.neg    = sign;
    rv.nan    = special & (ffld != '0);
    rv.snan   = special & (ffld != '0) & ~ffld[MAN_W-1];
    rv.inf    = special & (ffld == '0);
    rv.huge   = huge;
    rv.lost   = guard | sticky;
    rv.bumped = inc;
    rv.mag    = trunc_mag + MAG_W'(inc);
  end

endmodule

// File: rtl/f2i_select.sv
`timescale 1ns/1ps
module f2i_select
  import f2i_pkg::*;
(
  input  logic             neg,
  input  logic             nan,
  input  logic             inf,
  input  logic             huge,
  input  logic [MAG_W-1:0] mag,
  input  kind_e            kind,
  input  policy_e          policy,
  output logic [INT_W-1:0] value,
  output logic             unrep
);

  logic             fits;
  logic [INT_W-1:0] signed_val;
  logic [INT_W-1:0] raw;

  assign fits       = ~nan & ~inf & ~huge & kind_fits(kind, neg, mag);
  assign unrep      = ~fits;
  assign signed_val = neg ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];

  always_comb begin
    case (policy)
      POL_CLAMP_MIN, POL_CLAMP_ZERO: begin
        if (nan)       raw = (policy == POL_CLAMP_MIN) ? kind_min(kind) : '0;
        else if (fits) raw = signed_val;
        else if (neg)  raw = kind_min(kind);
        else           raw = kind_max(kind);
      end
      POL_WRAP: raw = (nan | inf | huge) ? '0 : signed_val;
      default:  raw = '0;
    endcase
    value = kind_shape(kind, raw);
  end

endmodule

// File: rtl/f2i_status.sv
`timescale 1ns/1ps
module f2i_status (
  input  logic illegal,
  input  logic unrep,
  input  logic snan,
  input  logic lost,
  input  logic bumped,
  input  logic inv_en,
  input  logic ovf_en,
  output logic wr_ok,
  output logic ovf,
  output logic inexact,
  output logic frac_rnd,
  output logic cvt_inv,
  output logic snan_flag
);

  logic trap;

  assign cvt_inv   = ~illegal & unrep;
  assign snan_flag = ~illegal & snan;
  assign trap      = inv_en & (cvt_inv | snan_flag);
  assign wr_ok     = ~illegal & ~trap;
  assign ovf       = ovf_en & cvt_inv;
  assign inexact   = ~illegal & ~cvt_inv & lost;
  assign frac_rnd  = ~illegal & ~cvt_inv & bumped;

endmodule

// File: rtl/f2i_convert.sv
`timescale 1ns/1ps
module f2i_convert
  import f2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [F64_W-1:0] in_operand,
  input  logic [1:0]       in_type,
  input  logic [2:0]       in_mode,
  input  logic [1:0]       in_rmode,
  input  logic             in_inv_en,
  input  logic             in_ovf_en,
  output logic             out_valid,
  output logic [INT_W-1:0] out_result,
  output logic             out_wr_en,
  output logic             out_overflow,
  output logic             out_inexact,
  output logic             out_frac_rnd,
  output logic             out_cvt_invalid,
  output logic             out_snan,
  output logic             out_illegal
);

  kind_e            kind;
  policy_e          policy;
  logic             ev_illegal;
  rounded_t         rv;
  logic [INT_W-1:0] sel_value;
  logic             ev_unrep;
  logic             ev_wr_ok;
  logic             ev_ovf;
  logic             ev_inexact;
  logic             ev_frac_rnd;
  logic             ev_cvt_inv;
  logic             ev_snan;
  kind_e            q_kind;

  assign kind       = kind_e'(in_type);
  assign policy     = policy_e'(in_mode[2:1]);
  assign ev_illegal = (policy == POL_BAD);

  f2i_unpack_round u_round (
    .op_bits     (in_operand),
    .rmode       (in_rmode),
    .force_trunc (in_mode[0]),
    .rv          (rv)
  );

  f2i_select u_select (
    .neg    (rv.neg),
    .nan    (rv.nan),
    .inf    (rv.inf),
    .huge   (rv.huge),
    .mag    (rv.mag),
    .kind   (kind),
    .policy (policy),
    .value  (sel_value),
    .unrep  (ev_unrep)
  );

  f2i_status u_status (
    .illegal   (ev_illegal),
    .unrep     (ev_unrep),
    .snan      (rv.snan),
    .lost      (rv.lost),
    .bumped    (rv.bumped),
    .inv_en    (in_inv_en),
    .ovf_en    (in_ovf_en),
    .wr_ok     (ev_wr_ok),
    .ovf       (ev_ovf),
    .inexact   (ev_inexact),
    .frac_rnd  (ev_frac_rnd),
    .cvt_inv   (ev_cvt_inv),
    .snan_flag (ev_snan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_result      <= '0;
      out_wr_en       <= 1'b0;
      out_overflow    <= 1'b0;
      out_inexact     <= 1'b0;
      out_frac_rnd    <= 1'b0;
      out_cvt_invalid <= 1'b0;
      out_snan        <= 1'b0;
      out_illegal     <= 1'b0;
      q_kind          <= K_S32;
    end else begin
      out_valid       <= in_valid;
      out_result      <= (in_valid && ev_wr_ok) ? sel_value : '0;
      out_wr_en       <= in_valid & ev_wr_ok;
      out_overflow    <= in_valid & ev_ovf;
      out_inexact     <= in_valid & ev_inexact;
      out_frac_rnd    <= in_valid & ev_frac_rnd;
      out_cvt_invalid <= in_valid & ev_cvt_inv;
      out_snan        <= in_valid & ev_snan;
      out_illegal     <= in_valid & ev_illegal;
      q_kind          <= kind;
    end
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_wr_en);
  // R6
  zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_kind == K_U32 |-> out_result[INT_W-1:HALF_W] == '0);
  // R6
  sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && q_kind == K_S32 |->
      out_result[INT_W-1:HALF_W] == {HALF_W{out_result[HALF_W-1]}});
  // R7
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_cvt_invalid |-> !out_inexact && !out_frac_rnd);
  // R8
  overflow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |-> $past(in_ovf_en) && out_cvt_invalid);
  // R9
  trap_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cvt_invalid && $past(in_inv_en) |-> !out_wr_en);
  // R9
  nowrite_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr_en |-> out_result == '0);
  // R10
  snan_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_snan |-> out_cvt_invalid);
  // R11
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> !out_wr_en && !out_cvt_invalid && !out_inexact && !out_overflow);
  // R12
  frac_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_frac_rnd |-> out_inexact);

endmodule

// File: tb/f2i_convert_test.sv
`timescale 1ns/1ps
module f2i_convert_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_operand;
  logic [1:0]  in_type;
  logic [2:0]  in_mode;
  logic [1:0]  in_rmode;
  logic        in_inv_en;
  logic        in_ovf_en;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_wr_en;
  logic        out_overflow;
  logic        out_inexact;
  logic        out_frac_rnd;
  logic        out_cvt_invalid;
  logic        out_snan;
  logic        out_illegal;

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic [5:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t mon_e;
  logic [5:0] mon_fl;
  int total = 0;
  int bad = 0;
  bit done = 0;

  f2i_convert uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_type(in_type), .in_mode(in_mode), .in_rmode(in_rmode),
    .in_inv_en(in_inv_en), .in_ovf_en(in_ovf_en), .out_valid(out_valid),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_overflow(out_overflow),
    .out_inexact(out_inexact), .out_frac_rnd(out_frac_rnd),
    .out_cvt_invalid(out_cvt_invalid), .out_snan(out_snan),
    .out_illegal(out_illegal)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // Flag vector order: {overflow, inexact, frac_rnd, cvt_invalid, snan, illegal}
  task automatic send(input logic [63:0] op, input logic [1:0] ty,
                      input logic [2:0] md, input logic [1:0] rm,
                      input logic ie, input logic oe,
                      input logic [63:0] er, input logic ew,
                      input logic [5:0] ef, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_type = ty; in_mode = md;
    in_rmode = rm; in_inv_en = ie; in_ovf_en = oe;
    e.res = er; e.we = ew; e.fl = ef; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0; in_operand = '0; in_type = '0; in_mode = '0;
    in_rmode = '0; in_inv_en = 1'b0; in_ovf_en = 1'b0;
  endtask

  // Monitor: pop the oldest expected item for every valid result.
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (q.size() == 0) begin
        chk(1'b0, $sformatf("R1 unexpected result act=%h exp=none", out_result));
      end else begin
        mon_e = q.pop_front();
        mon_fl = {out_overflow, out_inexact, out_frac_rnd, out_cvt_invalid,
                  out_snan, out_illegal};
        chk(out_result == mon_e.res && out_wr_en == mon_e.we && mon_fl == mon_e.fl,
            $sformatf("%s act res=%h we=%b fl=%b exp res=%h we=%b fl=%b",
                      mon_e.tag, out_result, out_wr_en, mon_fl,
                      mon_e.res, mon_e.we, mon_e.fl));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_operand = '0; in_type = '0; in_mode = '0;
    in_rmode = '0; in_inv_en = 1'b0; in_ovf_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_wr_en == 1'b0 && out_result == '0 &&
        {out_overflow, out_inexact, out_frac_rnd, out_cvt_invalid, out_snan, out_illegal} == '0,
        $sformatf("R1 reset state act valid=%b we=%b res=%h exp all zero",
                  out_valid, out_wr_en, out_result));
    rst_n = 1'b1;
    @(negedge clk);

    // op, type, mode, rmode, inv_en, ovf_en, result, we, flags, tag
    send(64'h4004_0000_0000_0000, 2'd0, 3'd0, 2'd0, 0, 0, 64'd2, 1, 6'b010000, "R2 2.5 nearest-even");
    send(64'h4004_0000_0000_0000, 2'd0, 3'd0, 2'd2, 0, 0, 64'd3, 1, 6'b011000, "R2 2.5 toward +inf");
    send(64'hC004_0000_0000_0000, 2'd2, 3'd0, 2'd3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFD, 1, 6'b011000, "R2 -2.5 toward -inf");
    send(64'hC004_0000_0000_0000, 2'd2, 3'd1, 2'd3, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1, 6'b010000, "R2 forced truncation");
    send(64'h3FF8_0000_0000_0000, 2'd1, 3'd0, 2'd0, 0, 0, 64'd2, 1, 6'b011000, "R2 1.5 tie to even up");
    send(64'h41E0_0000_0000_0000, 2'd0, 3'd0, 2'd0, 0, 1, 64'h0000_0000_7FFF_FFFF, 1, 6'b100100, "R3 2^31 to s32 max");
    send(64'h41E0_0000_0000_0000, 2'd1, 3'd0, 2'd0, 0, 0, 64'h0000_0000_8000_0000, 1, 6'b000000, "R6 2^31 u32 zero-extend");
    send(64'h41F0_0000_0000_0000, 2'd1, 3'd0, 2'd0, 0, 0, 64'h0000_0000_FFFF_FFFF, 1, 6'b000100, "R8 R3 2^32 u32 no ovf report");
    send(64'hBFF0_0000_0000_0000, 2'd3, 3'd0, 2'd0, 0, 0, 64'd0, 1, 6'b000100, "R3 -1 to u64 min");
    send(64'h43E0_0000_0000_0000, 2'd2, 3'd0, 2'd0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1, 6'b000100, "R3 2^63 to s64 max");
    send(64'h43E0_0000_0000_0000, 2'd3, 3'd0, 2'd0, 0, 0, 64'h8000_0000_0000_0000, 1, 6'b000000, "R3 2^63 u64 exact");
    send(64'h43F0_0000_0000_0000, 2'd3, 3'd0, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 6'b000100, "R3 2^64 to u64 max");
    send(64'hC1E0_0000_0000_0000, 2'd0, 3'd0, 2'd0, 0, 0, 64'hFFFF_FFFF_8000_0000, 1, 6'b000000, "R6 -2^31 s32 sign-extend");
    send(64'h7FF8_0000_0000_0000, 2'd0, 3'd0, 2'd0, 0, 0, 64'hFFFF_FFFF_8000_0000, 1, 6'b000100, "R3 qNaN to s32 min");
    send(64'h7FF8_0000_0000_0000, 2'd0, 3'd2, 2'd0, 0, 0, 64'd0, 1, 6'b000100, "R4 qNaN to zero");
    send(64'h41E0_0000_0000_0000, 2'd0, 3'd2, 2'd0, 0, 0, 64'h0000_0000_7FFF_FFFF, 1, 6'b000100, "R4 2^31 clamps to max");
    send(64'h7FF0_0000_0000_0000, 2'd2, 3'd2, 2'd0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1, 6'b000100, "R4 +inf clamps to max");
    send(64'h7FF0_0000_0000_0001, 2'd3, 3'd0, 2'd0, 0, 0, 64'd0, 1, 6'b000110, "R10 sNaN flagged");
    send(64'h7FF0_0000_0000_0001, 2'd2, 3'd0, 2'd0, 1, 0, 64'd0, 0, 6'b000110, "R9 sNaN with trap enable");
    send(64'h7FF0_0000_0000_0000, 2'd2, 3'd4, 2'd0, 0, 0, 64'd0, 1, 6'b000100, "R5 +inf wraps to zero");
    send(64'h43F0_0000_0000_0001, 2'd3, 3'd4, 2'd0, 0, 1, 64'h0000_0000_0000_1000, 1, 6'b100100, "R5 2^64+4096 wraps");
    send(64'hC1F0_0000_0010_0000, 2'd0, 3'd4, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 6'b000100, "R5 -(2^32+1) s32 wrap");
    send(64'hC004_0000_0000_0000, 2'd2, 3'd5, 2'd0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1, 6'b010000, "R5 in-range truncated");
    send(64'h47F0_0000_0000_0000, 2'd3, 3'd4, 2'd0, 0, 0, 64'd0, 1, 6'b000100, "R5 2^128 to zero");
    send(64'h4004_0000_0000_0000, 2'd1, 3'd4, 2'd0, 0, 0, 64'd2, 1, 6'b010000, "R5 2.5 rounded");
    send(64'h0000_0000_0000_0000, 2'd0, 3'd0, 2'd0, 0, 0, 64'd0, 1, 6'b000000, "R12 +0 exact");
    send(64'h8000_0000_0000_0000, 2'd1, 3'd0, 2'd0, 0, 0, 64'd0, 1, 6'b000000, "R12 -0 unsigned exact");
    send(64'h0000_0000_0000_0001, 2'd3, 3'd0, 2'd2, 0, 0, 64'd1, 1, 6'b011000, "R12 subnormal toward +inf");
    send(64'h0000_0000_0000_0001, 2'd3, 3'd0, 2'd0, 0, 0, 64'd0, 1, 6'b010000, "R12 subnormal nearest");
    send(64'hBFE0_0000_0000_0000, 2'd1, 3'd1, 2'd0, 0, 0, 64'd0, 1, 6'b010000, "R7 -0.5 truncates to 0");
    send(64'hBFE0_0000_0000_0000, 2'd1, 3'd0, 2'd3, 0, 0, 64'd0, 1, 6'b000100, "R7 -0.5 floors below range");
    send(64'h41E0_0000_0000_0000, 2'd0, 3'd0, 2'd0, 1, 1, 64'd0, 0, 6'b100100, "R9 overflow with trap enable");
    send(64'h3FF0_0000_0000_0000, 2'd0, 3'd6, 2'd0, 0, 1, 64'd0, 0, 6'b000001, "R11 policy 110 illegal");
    send(64'h7FF0_0000_0000_0001, 2'd0, 3'd7, 2'd0, 1, 1, 64'd0, 0, 6'b000001, "R11 policy 111 illegal");
    go_idle();
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, $sformatf("R1 idle act valid=%b exp 0", out_valid));
    chk(q.size() == 0, $sformatf("R1 outstanding act=%0d exp=0", q.size()));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule